// File: doc/BRIEF.md
# Serial long-shift and normalize sequencer

This block carries out the multi-place shift instructions of an extended arithmetic unit. It holds a link bit, an 18-bit accumulator (AC) and an 18-bit multiplier-quotient register (MQ). Operations move one place per clock under the control of a 6-bit step counter (SC). A single start strobe loads the opcode, a shift count and the three register values. The block then reports busy until the operation ends. After that, the shifted registers and the final SC value can be read at the outputs.

Seven operations are supported:
- long left and long right shifts across AC and MQ,
- signed forms of both long shifts,
- a left shift of AC alone,
- normalize and signed normalize, which end early as soon as the two top AC bits differ.

While a shift runs, the block refuses interrupt requests. A pending request is granted only once the sequencer is idle.

Bit numbering: AC0 and MQ0 are the most significant bits. On the ports these are ac_in[17] and mq_in[17], and AC17 and MQ17 are bit [0].

Top module: `eae_shift_seq`

## Requirements
- R1: After reset, busy is low and link_out, ac_out, mq_out and sc_out are all zero.
- R2: Opcode 0 (long left) does the following on each step. AC shifts toward AC0 and AC0 is discarded. MQ0 enters AC17, MQ shifts toward MQ0, and the link enters MQ17. The link itself is unchanged.
- R3: Opcode 1 (long right) does the following on each step. The link enters AC0 and AC17 enters MQ0. MQ17 is discarded and the link is unchanged.
- R4: Opcode 4 (AC-only left) does the following on each step. The link enters AC17 and AC0 is discarded. MQ is left unchanged, and MQ0 never reaches AC.
- R5: Opcodes 2 and 3 (signed left, signed right) first copy AC0 into the link, then shift as opcodes 0 and 1. Opcode 6 (signed normalize) does the same copy, then acts as opcode 5.
- R6: A plain shift with count n (0 to 36) moves n places. busy stays high for n+1 clocks and sc_out ends at 0. A count of 0 moves nothing.
- R7: Normalize (opcode 5/6) shifts left as opcode 0 while AC0 equals AC1. If AC0 differs from AC1 it stops without shifting. After k places with count n, sc_out = (k - n) mod 64.
- R8: Normalize loads SC with the ones' complement of the count, so a count of 1 gives 76 octal. If SC reaches 77 octal, normalize ends with sc_out = 77 octal.
- R9: irq_grant equals irq_req only while the sequencer is idle and no start is being accepted. While busy it is low.
- R10: A start while busy is ignored. A start with opcode 7 is ignored and leaves every output unchanged.
- R11: Let AC0 equal MQ17. Then a signed left 1, right 2, signed left 2, right 1 sequence returns the starting AC and MQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load strobe for a new operation |
| op | input | 3 | Operation code (0..6, 7 reserved) |
| count | input | 6 | Number of places |
| link_in | input | 1 | Starting link value |
| ac_in | input | 18 | Starting AC |
| mq_in | input | 18 | Starting MQ |
| irq_req | input | 1 | Interrupt request |
| link_out | output | 1 | Link register |
| ac_out | output | 18 | AC register |
| mq_out | output | 18 | MQ register |
| sc_out | output | 6 | Step counter |
| busy | output | 1 | Operation in progress |
| irq_grant | output | 1 | Interrupt taken this cycle |

## Verification
The properties assume that start is only meaningful as a single-cycle pulse and that a plain shift count stays within 0 to 36 places. The stimulus therefore pulses start for one clock and uses counts in that range. Inputs other than start are assumed don't-care while busy is high. The bench changes them only while idle, except for one deliberate overlapping start aimed at R10. The end-of-shift counter rule is also assumed: it relies on the loaded SC reaching exactly zero, which holds for any count.

// File: rtl/eae_seq_pkg.sv
package eae_seq_pkg;

    typedef enum logic [2:0] {
        OP_LONG_L     = 3'd0,
        OP_LONG_R     = 3'd1,
        OP_LONG_L_SGN = 3'd2,
        OP_LONG_R_SGN = 3'd3,
        OP_AC_L       = 3'd4,
        OP_NRM        = 3'd5,
        OP_NRM_SGN    = 3'd6,
        OP_RSV        = 3'd7
    } shift_op_e;

    typedef enum logic [1:0] {
        RT_LONG_LEFT  = 2'd0,
        RT_LONG_RIGHT = 2'd1,
        RT_AC_LEFT    = 2'd2
    } route_e;

    function automatic logic op_is_norm(shift_op_e op);
        return (op == OP_NRM) || (op == OP_NRM_SGN);
    endfunction

    function automatic logic op_is_signed(shift_op_e op);
        return (op == OP_LONG_L_SGN) || (op == OP_LONG_R_SGN) || (op == OP_NRM_SGN);
    endfunction

    function automatic route_e op_route(shift_op_e op);
        route_e r;
        case (op)
            OP_LONG_R, OP_LONG_R_SGN: r = RT_LONG_RIGHT;
            OP_AC_L:                  r = RT_AC_LEFT;
            default:                  r = RT_LONG_LEFT;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/eae_shift_net.sv
module eae_shift_net
    import eae_seq_pkg::*;
#(
    parameter int AW = 18,
    parameter int MW = 18
) (
    input  route_e          route,
    input  logic            link,
    input  logic [AW-1:0]   ac,
    input  logic [MW-1:0]   mq,
    output logic [AW-1:0]   ac_nx,
    output logic [MW-1:0]   mq_nx
);
    localparam int AC_TOP = AW - 1;
    localparam int MQ_TOP = MW - 1;

    // one place of movement; index [TOP] is the most significant (bit 0 in register terms)
    always_comb begin
        case (route)
            RT_LONG_RIGHT: begin
                ac_nx = {link, ac[AC_TOP:1]};
                mq_nx = {ac[0], mq[MQ_TOP:1]};
            end
            RT_AC_LEFT: begin
                ac_nx = {ac[AC_TOP-1:0], link};
                mq_nx = mq;
            end
            default: begin
                ac_nx = {ac[AC_TOP-1:0], mq[MQ_TOP]};
                mq_nx = {mq[MQ_TOP-1:0], link};
            end
        endcase
    end
endmodule

// File: rtl/eae_norm_detect.sv
module eae_norm_detect #(
    parameter int AW = 18
) (
    input  logic [AW-1:0] ac,
    output logic          normalized
);
    localparam int SIGN_BIT = AW - 1;
    localparam int NEXT_BIT = AW - 2;

    generate
        if (AW >= 2) begin : g_pair
            assign normalized = ac[SIGN_BIT] ^ ac[NEXT_BIT];
        end else begin : g_single
            assign normalized = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/eae_sc_unit.sv
module eae_sc_unit #(
    parameter int SCW = 6
) (
    input  logic [SCW-1:0] sc,
    input  logic [SCW-1:0] count,
    input  logic           norm_mode,
    output logic [SCW-1:0] load_val,
    output logic [SCW-1:0] sc_inc,
    output logic           at_zero,
    output logic           at_full
);
    localparam logic [SCW-1:0] ONE  = SCW'(1);
    localparam logic [SCW-1:0] FULL = {SCW{1'b1}};

    // plain shifts start at -n and end on zero; normalize starts at ~n and ends on all-ones
    assign load_val = norm_mode ? ~count : (~count + ONE);
    assign sc_inc   = sc + ONE;
    assign at_zero  = (sc == '0);
    assign at_full  = (sc == FULL);
endmodule

// File: rtl/eae_shift_seq.sv
module eae_shift_seq
    import eae_seq_pkg::*;
#(
    parameter int AW  = 18,
    parameter int MW  = 18,
    parameter int SCW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [SCW-1:0]  count,
    input  logic            link_in,
    input  logic [AW-1:0]   ac_in,
    input  logic [MW-1:0]   mq_in,
    input  logic            irq_req,
    output logic            link_out,
    output logic [AW-1:0]   ac_out,
    output logic [MW-1:0]   mq_out,
    output logic [SCW-1:0]  sc_out,
    output logic            busy,
    output logic            irq_grant
);
    localparam int AC_SIGN = AW - 1;

    typedef struct packed {
        logic            busy;
        shift_op_e       op;
        logic            link;
        logic [AW-1:0]   ac;
        logic [MW-1:0]   mq;
        logic [SCW-1:0]  sc;
    } seq_state_t;

    seq_state_t state_d, state_q;

    shift_op_e      op_req;
    shift_op_e      op_cur;
    logic           accept;
    logic [AW-1:0]  ac_step;
    logic [MW-1:0]  mq_step;
    logic           ac_normalized;
    logic [SCW-1:0] sc_load;
    logic [SCW-1:0] sc_next;
    logic           sc_zero;
    logic           sc_full;

    assign op_req = shift_op_e'(op);
    assign op_cur = state_q.op;
    assign accept = start && !state_q.busy && (op_req != OP_RSV);

    eae_shift_net #(.AW(AW), .MW(MW)) u_net (
        .route (op_route(state_q.op)),
        .link  (state_q.link),
        .ac    (state_q.ac),
        .mq    (state_q.mq),
        .ac_nx (ac_step),
        .mq_nx (mq_step)
    );

    eae_norm_detect #(.AW(AW)) u_norm (
        .ac         (state_q.ac),
        .normalized (ac_normalized)
    );

    eae_sc_unit #(.SCW(SCW)) u_sc (
        .sc        (state_q.sc),
        .count     (count),
        .norm_mode (op_is_norm(op_req)),
        .load_val  (sc_load),
        .sc_inc    (sc_next),
        .at_zero   (sc_zero),
        .at_full   (sc_full)
    );

    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d.busy = 1'b1;
            state_d.op   = op_req;
            state_d.link = op_is_signed(op_req) ? ac_in[AC_SIGN] : link_in;
            state_d.ac   = ac_in;
            state_d.mq   = mq_in;
            state_d.sc   = sc_load;
        end else if (state_q.busy) begin
            if (op_is_norm(state_q.op)) begin
                if (sc_full) begin
                    state_d.busy = 1'b0;
                end else if (ac_normalized) begin
                    state_d.sc   = sc_next;
                    state_d.busy = 1'b0;
                end else begin
                    state_d.ac = ac_step;
                    state_d.mq = mq_step;
                    state_d.sc = sc_next;
                end
            end else begin
                if (sc_zero) begin
                    state_d.busy = 1'b0;
                end else begin
                    state_d.ac = ac_step;
                    state_d.mq = mq_step;
                    state_d.sc = sc_next;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{busy: 1'b0, op: OP_LONG_L, link: 1'b0, ac: '0, mq: '0, sc: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign link_out  = state_q.link;
    assign ac_out    = state_q.ac;
    assign mq_out    = state_q.mq;
    assign sc_out    = state_q.sc;
    assign busy      = state_q.busy;
    assign irq_grant = irq_req && !state_q.busy && !accept;

endmodule

// File: rtl/eae_shift_seq_chk.sv
module eae_shift_seq_chk
    import eae_seq_pkg::*;
#(
    parameter int AW  = 18,
    parameter int MW  = 18,
    parameter int SCW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [2:0]      op,
    input logic            irq_grant,
    input logic            busy,
    input shift_op_e       op_cur,
    input logic            link_out,
    input logic [AW-1:0]   ac_out,
    input logic [MW-1:0]   mq_out,
    input logic [SCW-1:0]  sc_out
);
    // R6 R8
    sc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((sc_out == SCW'($past(sc_out) + 1'b1)) || (!busy && $stable(sc_out))));

    // R6
    plain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !op_is_norm(op_cur)) |-> (sc_out == '0));

    // R7
    norm_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_is_norm(op_cur) && (ac_out[AW-1] != ac_out[AW-2])) |=> (!busy && $stable(ac_out)));

    // R4
    acl_mq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_cur == OP_AC_L) |=> $stable(mq_out));

    // R5
    link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(link_out));

    // R9
    irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq_grant);

    // R10
    busy_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(op_cur));

    // R10
    rsv_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op == 3'd7) |=> (!busy && $stable(ac_out) && $stable(mq_out)));
endmodule

bind eae_shift_seq eae_shift_seq_chk #(.AW(AW), .MW(MW), .SCW(SCW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .irq_grant (irq_grant),
    .busy      (busy),
    .op_cur    (op_cur),
    .link_out  (link_out),
    .ac_out    (ac_out),
    .mq_out    (mq_out),
    .sc_out    (sc_out)
);

// File: tb/tb_eae_shift_seq.sv
`timescale 1ns/1ps
module tb_eae_shift_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [5:0]  count = '0;
    logic        link_in = 1'b0;
    logic [17:0] ac_in = '0;
    logic [17:0] mq_in = '0;
    logic        irq_req = 1'b0;
    logic        link_out, busy, irq_grant;
    logic [17:0] ac_out, mq_out;
    logic [5:0]  sc_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    eae_shift_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .count(count),
        .link_in(link_in), .ac_in(ac_in), .mq_in(mq_in), .irq_req(irq_req),
        .link_out(link_out), .ac_out(ac_out), .mq_out(mq_out), .sc_out(sc_out),
        .busy(busy), .irq_grant(irq_grant)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [5:0]  cnt;
        logic        l;
        logic [17:0] ac;
        logic [17:0] mq;
        logic        el;
        logic [17:0] eac;
        logic [17:0] emq;
        logic [5:0]  esc;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'd6, 3'd0, 6'd0,  1'b1, 18'o123456, 18'o654321, 1'b1, 18'o123456, 18'o654321, 6'o00},
        '{4'd2, 3'd0, 6'd1,  1'b1, 18'o400000, 18'o400000, 1'b1, 18'o000001, 18'o000001, 6'o00},
        '{4'd3, 3'd1, 6'd1,  1'b1, 18'o000001, 18'o000000, 1'b1, 18'o400000, 18'o400000, 6'o00},
        '{4'd3, 3'd1, 6'd1,  1'b1, 18'o402101, 18'o402101, 1'b1, 18'o601040, 18'o601040, 6'o00},
        '{4'd5, 3'd3, 6'd3,  1'b0, 18'o400000, 18'o000000, 1'b1, 18'o740000, 18'o000000, 6'o00},
        '{4'd5, 3'd2, 6'd3,  1'b0, 18'o456701, 18'o234567, 1'b1, 18'o567012, 18'o345677, 6'o00},
        '{4'd4, 3'd4, 6'd5,  1'b0, 18'o777776, 18'o777777, 1'b0, 18'o777700, 18'o777777, 6'o00},
        '{4'd4, 3'd4, 6'd1,  1'b1, 18'o000000, 18'o000000, 1'b1, 18'o000001, 18'o000000, 6'o00},
        '{4'd4, 3'd4, 6'd1,  1'b0, 18'o400000, 18'o400000, 1'b0, 18'o000000, 18'o400000, 6'o00},
        '{4'd8, 3'd5, 6'd1,  1'b0, 18'o200000, 18'o000000, 1'b0, 18'o200000, 18'o000000, 6'o77},
        '{4'd8, 3'd5, 6'd1,  1'b0, 18'o100000, 18'o000000, 1'b0, 18'o200000, 18'o000000, 6'o77},
        '{4'd8, 3'd5, 6'd36, 1'b0, 18'o000000, 18'o000000, 1'b0, 18'o000000, 18'o000000, 6'o77},
        '{4'd7, 3'd5, 6'd36, 1'b0, 18'o000010, 18'o000000, 1'b0, 18'o200000, 18'o000000, 6'o51},
        '{4'd7, 3'd6, 6'd36, 1'b0, 18'o777770, 18'o000000, 1'b1, 18'o400000, 18'o037777, 6'o52},
        '{4'd6, 3'd1, 6'd36, 1'b0, 18'o777777, 18'o777777, 1'b0, 18'o000000, 18'o000000, 6'o00},
        '{4'd2, 3'd0, 6'd18, 1'b1, 18'o000000, 18'o000000, 1'b1, 18'o000000, 18'o777777, 6'o00},
        '{4'd8, 3'd5, 6'd3,  1'b0, 18'o000000, 18'o000001, 1'b0, 18'o000000, 18'o000010, 6'o77}
    };

    function automatic string req_name(logic [3:0] n);
        case (n)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0o expected=%0o", req, what, act, exp);
        end
    endtask

    // pulse start at a falling edge, then wait for busy to drop; returns busy-cycle count
    task automatic run_op(input logic [2:0] o, input logic [5:0] n, input logic l,
                          input logic [17:0] a, input logic [17:0] m, output int bcyc);
        @(negedge clk);
        op = o; count = n; link_in = l; ac_in = a; mq_in = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bcyc = 0;
        while (busy && bcyc < 200) begin
            bcyc++;
            @(negedge clk);
        end
        if (bcyc >= 200) chk(1'b0, "R6", "hang", 64'(bcyc), 64'd0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            summary();
        end
    end

    initial begin
        int bc;
        logic [17:0] a0, m0;
        repeat (3) @(negedge clk);
        // R1 reset state
        irq_req = 1'b1;
        chk(busy == 1'b0 && link_out == 1'b0 && ac_out == '0 && mq_out == '0 && sc_out == '0,
            "R1", "reset state", {ac_out, mq_out, sc_out}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_grant == 1'b1, "R9", "idle grant", 64'(irq_grant), 64'd1);
        irq_req = 1'b0;

        // table walk (R2..R8)
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].op, VECS[i].cnt, VECS[i].l, VECS[i].ac, VECS[i].mq, bc);
            chk(link_out == VECS[i].el, req_name(VECS[i].req), "link", 64'(link_out), 64'(VECS[i].el));
            chk(ac_out == VECS[i].eac, req_name(VECS[i].req), "ac", 64'(ac_out), 64'(VECS[i].eac));
            chk(mq_out == VECS[i].emq, req_name(VECS[i].req), "mq", 64'(mq_out), 64'(VECS[i].emq));
            chk(sc_out == VECS[i].esc, req_name(VECS[i].req), "sc", 64'(sc_out), 64'(VECS[i].esc));
        end

        // R6 busy length n+1 for plain shift
        run_op(3'd1, 6'd5, 1'b0, 18'o111111, 18'o222222, bc);
        chk(bc == 6, "R6", "busy cycles count 5", 64'(bc), 64'd6);
        run_op(3'd0, 6'd0, 1'b0, 18'o111111, 18'o222222, bc);
        chk(bc == 1, "R6", "busy cycles count 0", 64'(bc), 64'd1);

        // R9 interrupt held during a shift
        @(negedge clk);
        op = 3'd1; count = 6'd36; link_in = 1'b0; ac_in = 18'o777777; mq_in = '0; start = 1'b1;
        irq_req = 1'b1;
        #0.1;
        chk(irq_grant == 1'b0, "R9", "grant on accept", 64'(irq_grant), 64'd0);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(irq_grant == 1'b0 && busy == 1'b1, "R9", "grant while busy", 64'(irq_grant), 64'd0);
        bc = 0;
        while (busy && bc < 200) begin bc++; @(negedge clk); end
        chk(irq_grant == 1'b1, "R9", "grant after done", 64'(irq_grant), 64'd1);
        irq_req = 1'b0;

        // R10 start while busy ignored
        @(negedge clk);
        op = 3'd0; count = 6'd10; link_in = 1'b0; ac_in = 18'o000000; mq_in = 18'o777777; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op = 3'd1; count = 6'd1; link_in = 1'b1; ac_in = 18'o555555; mq_in = 18'o000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bc = 0;
        while (busy && bc < 200) begin bc++; @(negedge clk); end
        chk(ac_out == 18'o001777 && mq_out == 18'o776000 && link_out == 1'b0 && sc_out == 6'o00,
            "R10", "start while busy", {ac_out, mq_out}, {18'o001777, 18'o776000});
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && ac_out == 18'o001777, "R10", "late start not taken", 64'(ac_out), 64'o001777);

        // R10 reserved opcode ignored
        @(negedge clk);
        op = 3'd7; count = 6'd4; link_in = 1'b1; ac_in = 18'o123123; mq_in = 18'o321321; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R10", "reserved busy", 64'(busy), 64'd0);
        chk(ac_out == 18'o001777 && mq_out == 18'o776000 && link_out == 1'b0,
            "R10", "reserved outputs", {ac_out, mq_out}, {18'o001777, 18'o776000});

        // R11 round-trip sequences (AC0 == MQ17)
        for (int s = 0; s < 2; s++) begin
            a0 = (s == 0) ? 18'o545670 : 18'o245670;
            m0 = (s == 0) ? 18'o123451 : 18'o711112;
            run_op(3'd2, 6'd1, 1'b0, a0, m0, bc);
            run_op(3'd1, 6'd2, link_out, ac_out, mq_out, bc);
            run_op(3'd2, 6'd2, link_out, ac_out, mq_out, bc);
            run_op(3'd1, 6'd1, link_out, ac_out, mq_out, bc);
            chk(ac_out == a0, "R11", "round trip ac", 64'(ac_out), 64'(a0));
            chk(mq_out == m0, "R11", "round trip mq", 64'(mq_out), 64'(m0));
        end

        // R1 reset mid-operation returns to the reset state
        @(negedge clk);
        op = 3'd0; count = 6'd30; ac_in = 18'o777777; mq_in = 18'o777777; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && ac_out == '0 && mq_out == '0 && sc_out == '0,
            "R1", "reset mid shift", {ac_out, mq_out}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        summary();
    end

endmodule